// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Registers

This block is the software-visible configuration bank of a DRAM controller. It holds a set of 32-bit words that a simple single-cycle word bus reaches through address, write enable, write data and read data. Word 0 holds a protection key, and word 1 is the controller configuration word. All other words up to the parameterised count are plain storage. Every word except the key is protected. It accepts writes only while the key word holds the unlock constant, so firmware must write the key before it changes the controller setup. It can write any other value to the key afterwards to protect the bank again.

A generation parameter picks one of two controller families. The family sets which configuration bits are read-only, what the configuration word holds after reset, and how the RAM-size parameter maps to the two-bit size code in bits [1:0]. A RAM size that the family does not support falls back to a fixed default code. A `locked` output reports the protection state.

Top module: `memctl_cfg_regs`

## Requirements
- R1: `locked` is 0 exactly while word 0 holds 0xFC600309. It is 1 for any other key value, including the reset value 0.
- R2: While `locked` is 1, a write to any word other than word 0 leaves that word unchanged.
- R3: A write to word 0 (byte address 0x000) is accepted whatever the lock state. The written value reads back unchanged.
- R4: A write to word 1 (byte address 0x004) keeps the current value of the read-only bits and takes the write data in the others. For family A the read-only bits are [31:11], 6 and [3:2] (mask 0xFFFFF84C). For family B they are [31:28], [19:14], 6 and [3:2] (mask 0xF00FC04C).
- R5: After reset, every word reads 0 except word 1. For family A, word 1 holds bit 6 set plus the size code in [1:0]. For family B, it holds 1 in [31:28], 3 in [3:2] and the size code in [1:0].
- R6: For family A, the size code is 0, 1, 2 or 3 for 64, 128, 256 or 512 MB, and 2 for any other size. For family B, it is 0, 1, 2 or 3 for 128, 256, 512 or 1024 MB, and 2 for any other size.
- R7: Word index = byte address >> 2. A read at an index at or beyond the word count (default 64) returns 0. A write there changes no word.
- R8: An address whose two low bits are not 00 reads as 0. A write there changes no word.
- R9: A write takes effect at the rising clock edge where `wrEn` is high. `rdData` follows `addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address within the 4 KB window |
| wrEn | input | 1 | Write strobe for the current address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| locked | output | 1 | 1 while the bank rejects protected writes |

## Verification
A wrong key comparison shows at `locked` on the cycle after the key write. A protection gate that leaks lets a dropped write reach storage, and the next read of that word returns the new data on the following cycle. A wrong read-only mask or reset constant shows as a bit difference the first time word 1 is read after a write or reset. Decode faults at range or alignment limits show as nonzero data at addresses that must read 0, or as a changed word on its next read. No fault stays hidden for more than one write-then-read pair.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  typedef enum logic { GEN_A = 1'b0, GEN_B = 1'b1 } gen_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrKey;
    logic wrConf;
    logic wrPlain;
    logic rdHit;
  } ctrl_strobe_t;

  function automatic logic [1:0] sizeCode(gen_e g, int unsigned megs);
    logic [1:0] code;
    if (g == GEN_A) begin
      case (megs)
        64:      code = 2'd0;
        128:     code = 2'd1;
        256:     code = 2'd2;
        512:     code = 2'd3;
        default: code = 2'd2;
      endcase
    end else begin
      case (megs)
        128:     code = 2'd0;
        256:     code = 2'd1;
        512:     code = 2'd2;
        1024:    code = 2'd3;
        default: code = 2'd2;
      endcase
    end
    return code;
  endfunction

  function automatic logic [31:0] roMask(gen_e g);
    logic [31:0] m;
    if (g == GEN_A) m = 32'hFFFF_F800 | 32'h0000_0040 | 32'h0000_000C;
    else            m = 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000
                      | 32'h0000_0040 | 32'h0000_000C;
    return m;
  endfunction

  function automatic logic [31:0] confReset(gen_e g, logic [1:0] code);
    logic [31:0] v;
    if (g == GEN_A) v = 32'h0000_0040 | {30'd0, code};
    else            v = 32'h1000_0000 | 32'h0000_000C | {30'd0, code};
    return v;
  endfunction

endpackage

// File: rtl/memctl_cfg_ctrl.sv
module memctl_cfg_ctrl
  import memctl_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              unlocked,
  output ctrl_strobe_t      strobe,
  output logic [IDX_W-1:0]  wordIdx
);

  localparam int unsigned SLOT_W = ADDR_W - 2;
  localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(NUM_WORDS);
  localparam logic [SLOT_W-1:0] SLOT_KEY   = '0;
  localparam logic [SLOT_W-1:0] SLOT_CONF  = SLOT_W'(1);

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              inRange;
  logic              hit;

  assign slot    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign inRange = (slot < SLOT_LIMIT);
  assign hit     = aligned && inRange;
  assign wordIdx = slot[IDX_W-1:0];

  always_comb begin
    strobe         = '0;
    strobe.rdHit   = hit;
    strobe.wrKey   = wrEn && hit && (slot == SLOT_KEY);
    strobe.wrConf  = wrEn && hit && unlocked && (slot == SLOT_CONF);
    strobe.wrPlain = wrEn && hit && unlocked && (slot > SLOT_CONF);
  end

endmodule

// File: rtl/memctl_cfg_dpath.sv
module memctl_cfg_dpath
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN       = GEN_A,
  parameter int unsigned RAM_MB    = 256,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             unlocked,
  output logic [31:0]      keyWord,
  output logic [31:0]      confWord
);

  localparam logic [1:0]  SIZE_CODE = sizeCode(GEN, RAM_MB);
  localparam logic [31:0] RO_MASK   = roMask(GEN);
  localparam logic [31:0] CONF_RST  = confReset(GEN, SIZE_CODE);

  logic [NUM_WORDS-1:0][31:0] wordBus;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic [31:0] q;
    if (w == 0) begin : gKey
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             q <= '0;
        else if (strobe.wrKey) q <= wrData;
      end
    end else if (w == 1) begin : gConf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= CONF_RST;
        else if (strobe.wrConf) q <= (q & RO_MASK) | (wrData & ~RO_MASK);
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strobe.wrPlain && (wordIdx == IDX_W'(w))) q <= wrData;
      end
    end
    assign wordBus[w] = q;
  end

  assign rdData   = strobe.rdHit ? wordBus[wordIdx] : '0;
  assign keyWord  = wordBus[0];
  assign confWord = wordBus[1];
  assign unlocked = (wordBus[0] == UNLOCK_KEY);

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN       = GEN_A,
  parameter int unsigned RAM_MB    = 256,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              locked
);

  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             unlocked;
  logic [31:0]      keyWord;
  logic [31:0]      confWord;

  memctl_cfg_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) uCtrl (
    .addr(addr), .wrEn(wrEn), .unlocked(unlocked),
    .strobe(strobe), .wordIdx(wordIdx)
  );

  memctl_cfg_dpath #(
    .GEN(GEN), .RAM_MB(RAM_MB), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wrData(wrData), .rdData(rdData), .unlocked(unlocked),
    .keyWord(keyWord), .confWord(confWord)
  );

  assign locked = ~unlocked;

endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN       = GEN_A,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              locked,
  input logic [31:0]       keyWord,
  input logic [31:0]       confWord
);

  localparam logic [ADDR_W-3:0] LIMIT = (ADDR_W-2)'(NUM_WORDS);
  localparam logic [31:0]       RO    = roMask(GEN);

  logic keyWrite;
  logic confWrite;
  assign keyWrite  = wrEn && (addr == '0);
  assign confWrite = wrEn && (addr == ADDR_W'(4));

  assert_unlock_key_R1: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && wrData == UNLOCK_KEY) |=> !locked);

  assert_relock_R1: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && wrData != UNLOCK_KEY) |=> locked);

  assert_locked_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (locked && confWrite) |=> $stable(confWord));

  assert_key_always_R3: assert property (@(posedge clk) disable iff (!rstN)
    keyWrite |=> (keyWord == $past(wrData)));

  assert_ro_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    confWrite |=> ((confWord & RO) == ($past(confWord) & RO)));

  assert_range_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1:2] >= LIMIT) |-> (rdData == '0));

  assert_unaligned_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (rdData == '0));

endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(
  .GEN(GEN), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .locked(locked), .keyWord(keyWord), .confWord(confWord)
);

// File: tb/memctl_cfg_regs_test.sv
module memctl_cfg_regs_test;
  import memctl_cfg_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdA, rdB, rdC;
  logic        lockA, lockB, lockC;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // family A, 256 MB -> code 2, conf reset 0x42
  memctl_cfg_regs #(.GEN(GEN_A), .RAM_MB(256)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdA), .locked(lockA));
  // family B, unsupported 300 MB -> fallback code 2, conf reset 0x1000000E
  memctl_cfg_regs #(.GEN(GEN_B), .RAM_MB(300)) uutB (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdB), .locked(lockB));
  // family A, 64 MB -> code 0, conf reset 0x40
  memctl_cfg_regs #(.GEN(GEN_A), .RAM_MB(64)) uutC (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdC), .locked(lockC));

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] expRd;
    logic        expLock;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h004, 32'h0,         32'h0000_0042, 1'b1}, // R5 R6 conf reset
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0000_0042, 1'b1}, // R2 conf write dropped
    '{1'b1, 12'h008, 32'h1234_5678, 32'h0,         1'b1}, // R2 plain write dropped
    '{1'b1, 12'h000, 32'hFC60_0309, 32'hFC60_0309, 1'b0}, // R1 R3 unlock
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0000_07F3, 1'b0}, // R4 R9 ro bits kept
    '{1'b1, 12'h004, 32'h0,         32'h0000_0040, 1'b0}, // R4 ro bit 6 kept
    '{1'b1, 12'h008, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R9 plain write
    '{1'b1, 12'h0FC, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0}, // R7 last word
    '{1'b1, 12'h100, 32'hDEAD_BEEF, 32'h0,         1'b0}, // R7 first out of range
    '{1'b1, 12'hFFC, 32'h1111_1111, 32'h0,         1'b0}, // R7 window top
    '{1'b1, 12'h00A, 32'h0,         32'h0,         1'b0}, // R8 unaligned
    '{1'b0, 12'h008, 32'h0,         32'h1234_5678, 1'b0}, // R8 R7 no word changed
    '{1'b1, 12'h000, 32'hFC60_0308, 32'hFC60_0308, 1'b1}, // R1 R3 relock
    '{1'b1, 12'h008, 32'h0,         32'h1234_5678, 1'b1}, // R2 dropped after relock
    '{1'b1, 12'h000, 32'hFC60_0309, 32'hFC60_0309, 1'b0}, // R1 unlock again
    '{1'b0, 12'h004, 32'h0,         32'h0000_0040, 1'b0}  // R4 conf held
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // drive one bus cycle; outputs sampled at the following falling edge
  task automatic busCycle(logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrEn = w; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    addr = '0; wrEn = 1'b0; wrData = '0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      applied++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    doReset();

    // reset state (R5, R6, R1)
    check("R1 reset locked A", {31'd0, lockA}, 32'd1);
    check("R5 reset key A", rdA, 32'd0);
    busCycle(1'b0, 12'h004, 32'd0);
    check("R6 conf B fallback", rdB, 32'h1000_000E);
    check("R6 conf A 64MB", rdC, 32'h0000_0040);

    // vector table on family A
    for (int i = 0; i < NV; i++) begin
      busCycle(VECS[i].wr, VECS[i].a, VECS[i].d);
      check($sformatf("vector %0d data", i), rdA, VECS[i].expRd);
      check($sformatf("vector %0d lock R1", i), {31'd0, lockA}, {31'd0, VECS[i].expLock});
    end

    // R9: read follows address within the same cycle
    @(negedge clk);
    addr = 12'h0FC; #1;
    check("R9 comb read 0x0FC", rdA, 32'hA5A5_A5A5);
    addr = 12'h008; #1;
    check("R9 comb read 0x008", rdA, 32'h1234_5678);

    // reset mid-run clears storage and relocks (R5)
    doReset();
    check("R1 relocked by reset", {31'd0, lockA}, 32'd1);
    busCycle(1'b0, 12'h008, 32'd0);
    check("R5 plain word cleared", rdA, 32'd0);
    busCycle(1'b0, 12'h004, 32'd0);
    check("R5 conf A restored", rdA, 32'h0000_0042);

    // family B read-only mask (R4)
    busCycle(1'b1, 12'h000, 32'hFC60_0309);
    check("R1 unlock B", {31'd0, lockB}, 32'd0);
    busCycle(1'b1, 12'h004, 32'hFFFF_FFFF);
    check("R4 conf B all ones", rdB, 32'h1FF0_3FBF);
    busCycle(1'b1, 12'h004, 32'h0);
    check("R4 conf B zeros", rdB, 32'h1000_000C);
    busCycle(1'b1, 12'h000, 32'h0);
    busCycle(1'b1, 12'h004, 32'hFFFF_FFFF);
    check("R2 conf B locked", rdB, 32'h1000_000C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule